// File: doc/BRIEF.md
# Bit-Serial Elastic Store with Fill Measurement

This block is a one-bit-wide circular buffer for a data-locked clock recovery loop. A recovered serial stream enters under a gated write clock. That clock may drop any number of pulses and space the rest unevenly. Bits leave under a separate, evenly paced read clock. Each side owns a modulo-depth address counter, and these counters serve as the write and read pointers.

The block has no full or empty flags. Writing never stalls: once the writer laps the ring, it replaces the oldest stored bit. The main output is a fill count, the number of unread bits, formed in the read clock domain by modular subtraction of the pointers. A clock synthesizer downstream steers the read rate so that this count stays near the middle of the ring.

The write pointer reaches the read domain as a Gray code through two flops and is converted back to binary before the subtraction. Reset places the read pointer half a ring behind the write pointer, so the store starts half full. One synchronous active-high reset is sampled by both clocks, and it must be held across several edges of each.

Top module: `bit_elastic_store`

## Requirements
- R1: While reset is sampled high, the write pointer becomes 0, the read pointer becomes DEPTH/2, `fill` reports DEPTH/2 (512 by default) and `rd_data` is 0. No bit is stored during reset.
- R2: On each rising `wr_clk` outside reset, `wr_data` is stored at the write pointer and the pointer advances by one. Missing or irregular `wr_clk` pulses only delay this.
- R3: On each rising `rd_clk` outside reset, the bit at the read pointer appears on `rd_data` and the read pointer advances by one. Bits therefore leave in the order they were written, and `rd_data` holds its value between read edges.
- R4: The write pointer wraps from DEPTH-1 to 0. Once more than DEPTH bits have been written without reads, each location holds its newest bit, and no flag or stall results.
- R5: The read pointer wraps from DEPTH-1 to 0 and keeps reading in the same order.
- R6: `fill` is the unsigned value (synchronized write pointer − read pointer) mod DEPTH, in the range 0 to DEPTH-1. After the last write, it is exact once three read edges have passed.
- R7: While the synchronized write pointer does not change, `fill` drops by exactly one on each read edge.
- R8: The write pointer is carried to the read domain as a Gray code, and exactly one bit of that code changes per write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Gated write clock; pulses may be missing |
| wr_data | input | 1 | Serial bit written on rising `wr_clk` |
| rd_clk | input | 1 | Synthesized read clock |
| rd_data | output | 1 | Serial bit read on rising `rd_clk` |
| rst | input | 1 | Synchronous active-high reset, sampled by both clocks |
| fill | output | $clog2(DEPTH) | Number of unread bits, registered on `rd_clk` |

## Verification
The bench builds the block with the default DEPTH of 1024, so the pointers are 10 bits wide. At that depth a lap of more than 1024 writes, wraps of both pointers and the half-full reset preset of 512 are all short sequences. Random gaps on both clocks, with the distance kept away from collision, run the read pointer around the ring many times. Between these runs the bench pauses writes and checks the settled fill count and its one-per-read decrement against a model of the pointers.

// File: rtl/esf_pkg.sv
package esf_pkg;

    localparam int unsigned DEF_DEPTH = 1024;

    typedef logic [31:0] word_t;

    // Pointer value as a wide word, zero extended
    typedef struct packed {
        logic [31:0] bin;
        logic [31:0] gray;
    } ptr_pair_t;

    function automatic word_t bin_to_gray(word_t b);
        return b ^ (b >> 1);
    endfunction

    function automatic word_t gray_to_bin(word_t g);
        word_t b;
        b = g;
        for (int s = 1; s < 32; s = s * 2) begin
            b = b ^ (b >> s);
        end
        return b;
    endfunction

    function automatic ptr_pair_t make_pair(word_t b);
        ptr_pair_t p;
        p.bin  = b;
        p.gray = bin_to_gray(b);
        return p;
    endfunction

    function automatic bit is_pow2(int unsigned v);
        return (v != 0) && ((v & (v - 1)) == 0);
    endfunction

endpackage

// File: rtl/esf_wr_ctrl.sv
module esf_wr_ctrl
    import esf_pkg::*;
#(
    parameter int unsigned DEPTH = DEF_DEPTH,
    localparam int unsigned AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    output logic [AW-1:0] wr_ptr,
    output logic [AW-1:0] wr_gray
);

    ptr_pair_t nxt;

    always_comb begin
        nxt = make_pair(word_t'(AW'(wr_ptr + 1'b1)));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr  <= '0;
            wr_gray <= '0;
        end else begin
            wr_ptr  <= nxt.bin[AW-1:0];
            wr_gray <= nxt.gray[AW-1:0];
        end
    end

endmodule

// File: rtl/esf_sync.sv
module esf_sync #(
    parameter int unsigned W = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end

endmodule

// File: rtl/esf_mem.sv
module esf_mem
    import esf_pkg::*;
#(
    parameter int unsigned DEPTH = DEF_DEPTH,
    localparam int unsigned AW = $clog2(DEPTH)
) (
    input  logic          wr_clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic          wr_bit,
    input  logic          rd_clk,
    input  logic          rd_rst,
    input  logic [AW-1:0] rd_addr,
    output logic          rd_bit
);

    logic ring [DEPTH];

    always_ff @(posedge wr_clk) begin
        if (wr_en) begin
            ring[wr_addr] <= wr_bit;
        end
    end

    always_ff @(posedge rd_clk) begin
        if (rd_rst) begin
            rd_bit <= 1'b0;
        end else begin
            rd_bit <= ring[rd_addr];
        end
    end

endmodule

// File: rtl/esf_rd_ctrl.sv
module esf_rd_ctrl
    import esf_pkg::*;
#(
    parameter int unsigned DEPTH = DEF_DEPTH,
    localparam int unsigned AW = $clog2(DEPTH),
    localparam int unsigned HALF = DEPTH / 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] wsync_gray,
    output logic [AW-1:0] rd_ptr,
    output logic [AW-1:0] fill
);

    logic [AW-1:0] wsync_bin;
    logic [AW-1:0] rd_nxt;

    always_comb begin
        wsync_bin = AW'(gray_to_bin(word_t'(wsync_gray)));
        rd_nxt    = AW'(rd_ptr + 1'b1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= AW'(DEPTH - HALF);
            fill   <= AW'(HALF);
        end else begin
            rd_ptr <= rd_nxt;
            fill   <= AW'(wsync_bin - rd_nxt);
        end
    end

endmodule

// File: rtl/bit_elastic_store.sv
module bit_elastic_store
    import esf_pkg::*;
#(
    parameter int unsigned DEPTH = DEF_DEPTH,
    localparam int unsigned AW = $clog2(DEPTH)
) (
    input  logic          wr_clk,
    input  logic          wr_data,
    input  logic          rd_clk,
    output logic          rd_data,
    input  logic          rst,
    output logic [AW-1:0] fill
);

    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] wr_gray;
    logic [AW-1:0] wgray_rd;
    logic [AW-1:0] rd_ptr;

    esf_wr_ctrl #(.DEPTH(DEPTH)) u_wr (
        .clk     (wr_clk),
        .rst     (rst),
        .wr_ptr  (wr_ptr),
        .wr_gray (wr_gray)
    );

    esf_sync #(.W(AW)) u_sync (
        .clk (rd_clk),
        .rst (rst),
        .d   (wr_gray),
        .q   (wgray_rd)
    );

    esf_rd_ctrl #(.DEPTH(DEPTH)) u_rd (
        .clk        (rd_clk),
        .rst        (rst),
        .wsync_gray (wgray_rd),
        .rd_ptr     (rd_ptr),
        .fill       (fill)
    );

    esf_mem #(.DEPTH(DEPTH)) u_mem (
        .wr_clk  (wr_clk),
        .wr_en   (!rst),
        .wr_addr (wr_ptr),
        .wr_bit  (wr_data),
        .rd_clk  (rd_clk),
        .rd_rst  (rst),
        .rd_addr (rd_ptr),
        .rd_bit  (rd_data)
    );

endmodule

// File: rtl/esf_chk.sv
module esf_chk #(
    parameter int unsigned DEPTH = 1024,
    localparam int unsigned AW = $clog2(DEPTH),
    localparam int unsigned HALF = DEPTH / 2
) (
    input logic          wr_clk,
    input logic          rd_clk,
    input logic          rst,
    input logic [AW-1:0] wr_ptr,
    input logic [AW-1:0] wr_gray,
    input logic [AW-1:0] rd_ptr,
    input logic [AW-1:0] sync_gray,
    input logic [AW-1:0] fill
);

    logic wr_rst_seen = 1'b0;
    logic rd_rst_seen = 1'b0;

    always_ff @(posedge wr_clk) wr_rst_seen <= rst;
    always_ff @(posedge rd_clk) rd_rst_seen <= rst;

    // R1: reset state as seen between edges
    always @(negedge wr_clk) begin
        if (wr_rst_seen) begin
            assert_wr_reset_R1: assert (wr_ptr == '0);
        end
    end

    always @(negedge rd_clk) begin
        if (rd_rst_seen) begin
            assert_rd_reset_R1: assert (rd_ptr == AW'(HALF) && fill == AW'(HALF));
        end
    end

    // R2, R4: one step per write edge, wrapping modulo DEPTH
    assert_wr_step_R2: assert property (@(posedge wr_clk) disable iff (rst)
        !rst |=> wr_ptr == AW'($past(wr_ptr) + 1'b1));

    // R3, R5: one step per read edge, wrapping modulo DEPTH
    assert_rd_step_R3: assert property (@(posedge rd_clk) disable iff (rst)
        !rst |=> rd_ptr == AW'($past(rd_ptr) + 1'b1));

    // R8: single-bit change of the crossing code per write
    assert_gray_step_R8: assert property (@(posedge wr_clk) disable iff (rst)
        !rst |=> $countones(wr_gray ^ $past(wr_gray)) == 1);

    // R7: steady synchronized pointer means fill drains by one per read
    assert_fill_drain_R7: assert property (@(posedge rd_clk) disable iff (rst)
        (sync_gray == $past(sync_gray)) |=> fill == AW'($past(fill) - 1'b1));

endmodule

bind bit_elastic_store esf_chk #(.DEPTH(DEPTH)) u_chk (
    .wr_clk    (wr_clk),
    .rd_clk    (rd_clk),
    .rst       (rst),
    .wr_ptr    (wr_ptr),
    .wr_gray   (wr_gray),
    .rd_ptr    (rd_ptr),
    .sync_gray (wgray_rd),
    .fill      (fill)
);

// File: tb/bit_elastic_store_tb.sv
module bit_elastic_store_tb;

    localparam int DEPTH = 1024;
    localparam int AW    = $clog2(DEPTH);
    localparam int HALF  = DEPTH / 2;

    logic clk = 1'b0;
    logic wr_gate = 1'b0;
    logic rd_gate = 1'b0;
    logic rst = 1'b1;
    logic wr_data = 1'b0;
    logic rd_data;
    logic [AW-1:0] fill;
    wire wr_clk = clk & wr_gate;
    wire rd_clk = clk & rd_gate;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    bit model_mem [DEPTH];
    int wp = 0;
    int rp = HALF;

    always #2 clk = ~clk;

    bit_elastic_store #(.DEPTH(DEPTH)) u_dut (
        .wr_clk  (wr_clk),
        .wr_data (wr_data),
        .rd_clk  (rd_clk),
        .rd_data (rd_data),
        .rst     (rst),
        .fill    (fill)
    );

    function automatic int exp_fill();
        return (wp - rp) & (DEPTH - 1);
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Entered and left at a falling clk edge
    task automatic step(bit we, bit re, bit b, string tag);
        bit exp_bit;
        wr_gate = we;
        rd_gate = re;
        wr_data = b;
        exp_bit = model_mem[rp];
        if (we) model_mem[wp] = b;
        @(negedge clk);
        wr_gate = 1'b0;
        rd_gate = 1'b0;
        if (re) begin
            check(rd_data == exp_bit, tag, int'(rd_data), int'(exp_bit));
            rp = (rp + 1) % DEPTH;
        end
        if (we) wp = (wp + 1) % DEPTH;
    endtask

    task automatic settle_fill(string tag);
        repeat (3) step(1'b0, 1'b1, 1'b0, "R3 read data");
        check(int'(fill) == exp_fill(), tag, int'(fill), exp_fill());
    endtask

    task automatic do_reset();
        rst = 1'b1;
        wr_gate = 1'b1;
        rd_gate = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        wr_gate = 1'b0;
        rd_gate = 1'b0;
        wp = 0;
        rp = HALF;
        check(int'(fill) == HALF, "R1 reset fill", int'(fill), HALF);
        check(rd_data == 1'b0, "R1 reset rd_data", int'(rd_data), 0);
    endtask

    initial begin
        void'($urandom(32'h5eed_0042));
        @(negedge clk);
        do_reset();

        // Fill the whole ring without reading: write pointer wraps (R4)
        for (int i = 0; i < DEPTH; i++) step(1'b1, 1'b0, 1'($urandom % 2), "R2 write");
        check(wp == 0, "R4 model wrap", wp, 0);
        settle_fill("R4 R6 fill after prime");

        // R7: steady write pointer, fill drops by one per read
        for (int i = 0; i < 4; i++) begin
            step(1'b0, 1'b1, 1'b0, "R3 read data");
            check(int'(fill) == exp_fill(), "R7 drain", int'(fill), exp_fill());
        end

        // Random gapped clocks on both sides; read pointer wraps (R5)
        for (int i = 0; i < 20000; i++) begin
            int d;
            bit we;
            bit re;
            d  = exp_fill();
            we = (($urandom % 4) != 0) && (d < 1000);
            re = (($urandom % 4) != 0) && (d > 24);
            step(we, re, 1'($urandom % 2), "R2 R3 R5 random read data");
            if ((i % 1000) == 999) settle_fill("R6 R8 settled fill");
        end

        // Lap the reader: newest bit must win at each location (R4)
        for (int i = 0; i < DEPTH + 76; i++) step(1'b1, 1'b0, 1'($urandom % 2), "R2 write");
        for (int i = 0; i < 40; i++) step(1'b0, 1'b1, 1'b0, "R4 overwrite read data");
        settle_fill("R4 R6 fill after lap");

        // Reset in mid run, then read stored bits from the preset position
        @(negedge clk);
        do_reset();
        for (int i = 0; i < 10; i++) step(1'b0, 1'b1, 1'b0, "R1 R3 read after reset");
        check(int'(fill) == exp_fill(), "R6 fill after reset reads", int'(fill), exp_fill());

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule